// File: doc/BRIEF.md
# CAM Persistent Data-Path Selector

This block is the command-side controller in front of a content-addressable memory that has a 16-bit data bus. Command words set two persistent modes. One picks the source that data read cycles return. The other picks the target that data write cycles update, and it can also name a mask register. Each mode stays in force across any number of data cycles. It changes only when a new command of the same kind arrives, or on reset.

A stored word is 64 bits wide and moves as four 16-bit segments. A separate segment counter for each direction walks a configurable window of segments. The targets are a comparand register, two mask registers and a memory array. The memory array stands in for the match array. An address register points into the memory. It can be loaded from a command, or left as it stands. It steps up or down after each full-word memory access. A write may be bit-masked. When the final segment of the comparand or of a mask register is written, a one-cycle compare-request pulse is raised.

Top module: `camPathSelector`

## Requirements
- R1: After reset, reads come from the comparand and writes go to the comparand with no mask. The comparand, both mask registers, the address register and both segment offsets are zero, and `compareReq` is low.
- R2: The command word `0000 f000 0000 0sss` selects the read source. sss=000 is the comparand, 001 mask register 1, 010 mask register 2, 100 memory at the address register. The source holds across data cycles until the next valid source command.
- R3: The command word `0000 f001 mmdd dvvv` selects the write target. ddd uses the same codes as sss. The target holds until the next valid destination command. Writing to one target leaves the other registers unchanged.
- R4: mm=01 masks with mask register 1 and mm=10 with mask register 2. mm=00 and mm=11 mean no mask. Masking applies only when the target is the comparand or the memory. Only the data bits whose mask bit is 0 are written.
- R5: `compareReq` is high for exactly the one cycle after a write to the final segment of the window whose target is the comparand or a mask register. No other write raises it, and no memory write ever does.
- R6: A source or destination command with f=1 and a memory code treats the next command word as an address. Its low ADDR_W bits are loaded into the address register, and the first memory access uses that address. With f=0 the address register keeps its value.
- R7: After the final segment of a memory read or write, the address register steps by one. It counts up when `addrDecr`=0 and down when `addrDecr`=1, wrapping modulo 2^ADDR_W. No other cycle changes it, apart from a load.
- R8: Segment n is bits [16n+15:16n]. The write counter starts at `wrSegStart`, advances by one per write modulo 4, and returns to `wrSegStart` after writing `wrSegEnd`. The read counter behaves the same way with `rdSegStart`/`rdSegEnd`. A valid destination command restarts the write counter and a valid source command restarts the read counter.
- R9: A command word that is not a valid source or destination command changes no selection, counter or address. This covers a non-zero top nibble, a wrong opcode field, or an unlisted sss/ddd code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command word present this cycle |
| cmdData | input | 16 | Command word, or an address word after an f=1 memory command |
| dataWrValid | input | 1 | Data write cycle (ignored while cmdValid) |
| dataWrData | input | 16 | Write data segment |
| dataRdValid | input | 1 | Data read cycle; advances the read counter (ignored while cmdValid) |
| dataRdData | output | 16 | Current segment of the selected read source |
| addrDecr | input | 1 | Address step direction: 0 up, 1 down |
| wrSegStart | input | 2 | First segment of the write window |
| wrSegEnd | input | 2 | Final segment of the write window |
| rdSegStart | input | 2 | First segment of the read window |
| rdSegEnd | input | 2 | Final segment of the read window |
| compareReq | output | 1 | One-cycle compare request |
| addrOut | output | ADDR_W | Current address register |

## Verification
The assertions check every cycle that the source and destination modes hold while no command arrives. They also check that a masked comparand write never changes a bit whose mask bit is set, that a memory write leaves the comparand untouched, that the address register moves only on a load or a final-segment memory access, and that each compare request and pending address load follows its cause. The bench scenarios cover the rest. These are the segment order and window wrap, the address wrap when counting down, the bit result of a masked merge, the rejection of malformed command words, and the return to the reset defaults in the middle of a run.

// File: rtl/camPathPkg.sv
package camPathPkg;
  localparam int SEG_W  = 16;
  localparam int SEG_N  = 4;
  localparam int SEG_IW = $clog2(SEG_N);
  localparam int WORD_W = SEG_W * SEG_N;

  typedef enum logic [2:0] {
    TGT_COMP  = 3'b000,
    TGT_MASK1 = 3'b001,
    TGT_MASK2 = 3'b010,
    TGT_MEM   = 3'b100
  } tgt_e;

  typedef struct packed {
    logic              wrEn;
    tgt_e              wrTgt;
    logic [1:0]        wrMask;
    logic [SEG_IW-1:0] wrSeg;
    tgt_e              rdTgt;
    logic [SEG_IW-1:0] rdSeg;
  } strobe_t;
endpackage

// File: rtl/camPathCtrl.sv
module camPathCtrl
  import camPathPkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [15:0]       cmdData,
  input  logic              dataWrValid,
  input  logic              dataRdValid,
  input  logic              addrDecr,
  input  logic [SEG_IW-1:0] wrSegStart,
  input  logic [SEG_IW-1:0] wrSegEnd,
  input  logic [SEG_IW-1:0] rdSegStart,
  input  logic [SEG_IW-1:0] rdSegEnd,
  output strobe_t           strobe,
  output logic [ADDR_W-1:0] arQ,
  output logic              compareReq
);

  tgt_e              srcQ, dstQ;
  logic [1:0]        maskQ;
  logic              addrPend;
  logic [SEG_IW-1:0] wrOffQ, rdOffQ;

  function automatic logic tgtOk(input logic [2:0] code);
    return (code == TGT_COMP) || (code == TGT_MASK1) ||
           (code == TGT_MASK2) || (code == TGT_MEM);
  endfunction

  // command decode
  logic opTop, addrFlag, spsHit, spdHit, needAddr, arLoad;
  assign opTop    = (cmdData[15:12] == 4'h0);
  assign addrFlag = cmdData[11];
  assign spsHit   = cmdValid && !addrPend && opTop && (cmdData[10:8] == 3'b000) &&
                    (cmdData[7:3] == 5'd0) && tgtOk(cmdData[2:0]);
  assign spdHit   = cmdValid && !addrPend && opTop && (cmdData[10:8] == 3'b001) &&
                    tgtOk(cmdData[5:3]);
  assign needAddr = addrFlag && ((spsHit && cmdData[2:0] == TGT_MEM) ||
                                 (spdHit && cmdData[5:3] == TGT_MEM));
  assign arLoad   = cmdValid && addrPend;

  // data cycle qualification and segment tracking
  logic              wrEn, rdEn, wrLast, rdLast, memStep;
  logic [SEG_IW-1:0] wrSeg, rdSeg;
  assign wrEn    = dataWrValid && !cmdValid;
  assign rdEn    = dataRdValid && !cmdValid;
  assign wrSeg   = wrSegStart + wrOffQ;
  assign rdSeg   = rdSegStart + rdOffQ;
  assign wrLast  = wrEn && (wrSeg == wrSegEnd);
  assign rdLast  = rdEn && (rdSeg == rdSegEnd);
  assign memStep = (wrLast && dstQ == TGT_MEM) || (rdLast && srcQ == TGT_MEM);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcQ       <= TGT_COMP;
      dstQ       <= TGT_COMP;
      maskQ      <= 2'b00;
      addrPend   <= 1'b0;
      arQ        <= '0;
      wrOffQ     <= '0;
      rdOffQ     <= '0;
      compareReq <= 1'b0;
    end else begin
      compareReq <= wrLast && (dstQ != TGT_MEM);

      if (spsHit) begin
        srcQ   <= tgt_e'(cmdData[2:0]);
        rdOffQ <= '0;
      end else if (rdEn) begin
        rdOffQ <= rdLast ? '0 : rdOffQ + 1'b1;
      end

      if (spdHit) begin
        dstQ   <= tgt_e'(cmdData[5:3]);
        maskQ  <= cmdData[7:6];
        wrOffQ <= '0;
      end else if (wrEn) begin
        wrOffQ <= wrLast ? '0 : wrOffQ + 1'b1;
      end

      if (needAddr)    addrPend <= 1'b1;
      else if (arLoad) addrPend <= 1'b0;

      if (arLoad)       arQ <= cmdData[ADDR_W-1:0];
      else if (memStep) arQ <= addrDecr ? arQ - 1'b1 : arQ + 1'b1;
    end
  end

  assign strobe = '{wrEn: wrEn, wrTgt: dstQ, wrMask: maskQ, wrSeg: wrSeg,
                    rdTgt: srcQ, rdSeg: rdSeg};

  AST_SRC_PERSIST: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> $stable(srcQ)); // R2
  AST_DST_PERSIST: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> $stable(dstQ) && $stable(maskQ)); // R3
  AST_CMP_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    compareReq |-> $past(dataWrValid) && !$past(cmdValid)); // R5
  AST_ADDR_PEND_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(addrPend) |-> $past(cmdValid)); // R6
  AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdValid && !dataWrValid && !dataRdValid) |=> $stable(arQ)); // R7
endmodule

// File: rtl/camPathData.sv
module camPathData
  import camPathPkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [ADDR_W-1:0] arQ,
  input  logic [SEG_W-1:0]  dataWrData,
  output logic [SEG_W-1:0]  dataRdData
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [WORD_W-1:0] compQ, mask1Q, mask2Q;
  logic [WORD_W-1:0] memArr [DEPTH];
  logic [WORD_W-1:0] memWord, oldWord, maskWord, effMask, mergedWord, srcWord;

  assign memWord = memArr[arQ];

  always_comb begin
    case (strobe.wrTgt)
      TGT_MASK1: oldWord = mask1Q;
      TGT_MASK2: oldWord = mask2Q;
      TGT_MEM:   oldWord = memWord;
      default:   oldWord = compQ;
    endcase
    case (strobe.wrMask)
      2'b01:   maskWord = mask1Q;
      2'b10:   maskWord = mask2Q;
      default: maskWord = '0;
    endcase
    effMask = (strobe.wrTgt == TGT_COMP || strobe.wrTgt == TGT_MEM) ? maskWord : '0;
  end

  // per-segment masked merge
  for (genvar g = 0; g < SEG_N; g++) begin : gSeg
    logic segSel;
    assign segSel = strobe.wrEn && (strobe.wrSeg == SEG_IW'(g));
    assign mergedWord[g*SEG_W +: SEG_W] = segSel ?
      ((oldWord[g*SEG_W +: SEG_W] & effMask[g*SEG_W +: SEG_W]) |
       (dataWrData & ~effMask[g*SEG_W +: SEG_W])) :
      oldWord[g*SEG_W +: SEG_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      compQ  <= '0;
      mask1Q <= '0;
      mask2Q <= '0;
    end else if (strobe.wrEn) begin
      case (strobe.wrTgt)
        TGT_COMP:  compQ  <= mergedWord;
        TGT_MASK1: mask1Q <= mergedWord;
        TGT_MASK2: mask2Q <= mergedWord;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn && strobe.wrTgt == TGT_MEM) memArr[arQ] <= mergedWord;
  end

  always_comb begin
    case (strobe.rdTgt)
      TGT_MASK1: srcWord = mask1Q;
      TGT_MASK2: srcWord = mask2Q;
      TGT_MEM:   srcWord = memWord;
      default:   srcWord = compQ;
    endcase
  end
  assign dataRdData = srcWord[strobe.rdSeg*SEG_W +: SEG_W];

  AST_MASK1_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && strobe.wrTgt == TGT_COMP && strobe.wrMask == 2'b01)
    |=> ((compQ ^ $past(compQ)) & $past(mask1Q)) == '0); // R4
  AST_MASK2_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && strobe.wrTgt == TGT_COMP && strobe.wrMask == 2'b10)
    |=> ((compQ ^ $past(compQ)) & $past(mask2Q)) == '0); // R4
  AST_MEM_WR_ISOLATED: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && strobe.wrTgt == TGT_MEM)
    |=> $stable(compQ) && $stable(mask1Q) && $stable(mask2Q)); // R3
endmodule

// File: rtl/camPathSelector.sv
module camPathSelector
  import camPathPkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [15:0]       cmdData,
  input  logic              dataWrValid,
  input  logic [15:0]       dataWrData,
  input  logic              dataRdValid,
  output logic [15:0]       dataRdData,
  input  logic              addrDecr,
  input  logic [1:0]        wrSegStart,
  input  logic [1:0]        wrSegEnd,
  input  logic [1:0]        rdSegStart,
  input  logic [1:0]        rdSegEnd,
  output logic              compareReq,
  output logic [ADDR_W-1:0] addrOut
);
  strobe_t           strobe;
  logic [ADDR_W-1:0] arQ;

  camPathCtrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdData(cmdData),
    .dataWrValid(dataWrValid), .dataRdValid(dataRdValid), .addrDecr(addrDecr),
    .wrSegStart(wrSegStart), .wrSegEnd(wrSegEnd),
    .rdSegStart(rdSegStart), .rdSegEnd(rdSegEnd),
    .strobe(strobe), .arQ(arQ), .compareReq(compareReq)
  );

  camPathData #(.ADDR_W(ADDR_W)) i_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .arQ(arQ),
    .dataWrData(dataWrData), .dataRdData(dataRdData)
  );

  assign addrOut = arQ;
endmodule

// File: tb/test_camPathSelector.sv
`timescale 1ns/1ps
module test_camPathSelector;
  localparam int ADDR_W = 4;
  localparam logic [2:0] OP_CMD = 3'd0, OP_WR = 3'd1, OP_RD = 3'd2,
                         OP_CMP = 3'd3, OP_AR = 3'd4;
  localparam int NV = 63;

  // {op, value, expected, requirement}
  localparam logic [38:0] VEC [NV] = '{
    {OP_CMD, 16'h0100, 16'h0000, 4'd3},   // R3 dest comparand
    {OP_WR,  16'h1111, 16'h0000, 4'd3},
    {OP_WR,  16'h2222, 16'h0000, 4'd3},
    {OP_WR,  16'h3333, 16'h0000, 4'd3},
    {OP_CMP, 16'h0000, 16'h0000, 4'd5},   // R5 no pulse before final segment
    {OP_WR,  16'h4444, 16'h0000, 4'd3},
    {OP_CMP, 16'h0000, 16'h0001, 4'd5},   // R5 pulse
    {OP_CMP, 16'h0000, 16'h0000, 4'd5},   // R5 only one cycle
    {OP_CMD, 16'h0000, 16'h0000, 4'd2},   // R2 source comparand
    {OP_RD,  16'h0000, 16'h1111, 4'd2},
    {OP_RD,  16'h0000, 16'h2222, 4'd8},   // R8 ascending segments
    {OP_RD,  16'h0000, 16'h3333, 4'd8},
    {OP_RD,  16'h0000, 16'h4444, 4'd8},
    {OP_RD,  16'h0000, 16'h1111, 4'd8},   // R8 wrap
    {OP_CMD, 16'h0108, 16'h0000, 4'd3},   // R3 dest mask1
    {OP_WR,  16'h00FF, 16'h0000, 4'd3},
    {OP_WR,  16'h00FF, 16'h0000, 4'd3},
    {OP_WR,  16'h00FF, 16'h0000, 4'd3},
    {OP_WR,  16'h00FF, 16'h0000, 4'd3},
    {OP_CMP, 16'h0000, 16'h0001, 4'd5},   // R5 mask target pulses
    {OP_CMD, 16'h0001, 16'h0000, 4'd2},   // R2 source mask1
    {OP_RD,  16'h0000, 16'h00FF, 4'd2},
    {OP_CMD, 16'h0140, 16'h0000, 4'd4},   // R4 comparand masked by mask1
    {OP_WR,  16'hABCD, 16'h0000, 4'd4},
    {OP_WR,  16'hABCD, 16'h0000, 4'd4},
    {OP_WR,  16'hABCD, 16'h0000, 4'd4},
    {OP_WR,  16'hABCD, 16'h0000, 4'd4},
    {OP_CMP, 16'h0000, 16'h0001, 4'd5},
    {OP_CMD, 16'h0000, 16'h0000, 4'd2},
    {OP_RD,  16'h0000, 16'hAB11, 4'd4},   // R4 masked merge
    {OP_RD,  16'h0000, 16'hAB22, 4'd4},
    {OP_CMD, 16'h0920, 16'h0000, 4'd6},   // R6 dest memory with address
    {OP_CMD, 16'h0005, 16'h0000, 4'd6},
    {OP_AR,  16'h0000, 16'h0005, 4'd6},
    {OP_WR,  16'hA000, 16'h0000, 4'd3},
    {OP_WR,  16'hA001, 16'h0000, 4'd3},
    {OP_WR,  16'hA002, 16'h0000, 4'd3},
    {OP_WR,  16'hA003, 16'h0000, 4'd3},
    {OP_CMP, 16'h0000, 16'h0000, 4'd5},   // R5 memory never pulses
    {OP_AR,  16'h0000, 16'h0006, 4'd7},   // R7 step up
    {OP_WR,  16'hB000, 16'h0000, 4'd3},
    {OP_WR,  16'hB001, 16'h0000, 4'd3},
    {OP_WR,  16'hB002, 16'h0000, 4'd3},
    {OP_WR,  16'hB003, 16'h0000, 4'd3},
    {OP_AR,  16'h0000, 16'h0007, 4'd7},
    {OP_CMD, 16'h0804, 16'h0000, 4'd6},   // R6 source memory with address
    {OP_CMD, 16'h0005, 16'h0000, 4'd6},
    {OP_RD,  16'h0000, 16'hA000, 4'd6},
    {OP_RD,  16'h0000, 16'hA001, 4'd2},
    {OP_RD,  16'h0000, 16'hA002, 4'd2},
    {OP_RD,  16'h0000, 16'hA003, 4'd2},
    {OP_AR,  16'h0000, 16'h0006, 4'd7},   // R7 read steps too
    {OP_CMD, 16'h0007, 16'h0000, 4'd9},   // R9 unlisted code
    {OP_CMD, 16'hF004, 16'h0000, 4'd9},   // R9 bad top nibble
    {OP_RD,  16'h0000, 16'hB000, 4'd9},   // R9 source and counter kept
    {OP_RD,  16'h0000, 16'hB001, 4'd9},
    {OP_RD,  16'h0000, 16'hB002, 4'd2},
    {OP_RD,  16'h0000, 16'hB003, 4'd2},
    {OP_CMD, 16'h0804, 16'h0000, 4'd6},
    {OP_CMD, 16'h0006, 16'h0000, 4'd6},
    {OP_RD,  16'h0000, 16'hB000, 4'd6},
    {OP_CMD, 16'h0004, 16'h0000, 4'd6},   // R6 f=0 keeps address
    {OP_RD,  16'h0000, 16'hB000, 4'd6}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic cmdValid = 1'b0, dataWrValid = 1'b0, dataRdValid = 1'b0, addrDecr = 1'b0;
  logic [15:0] cmdData = '0, dataWrData = '0, dataRdData;
  logic [1:0] wrSegStart = 2'd0, wrSegEnd = 2'd3, rdSegStart = 2'd0, rdSegEnd = 2'd3;
  logic compareReq;
  logic [ADDR_W-1:0] addrOut;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  camPathSelector #(.ADDR_W(ADDR_W)) i_camPathSelector (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdData(cmdData),
    .dataWrValid(dataWrValid), .dataWrData(dataWrData),
    .dataRdValid(dataRdValid), .dataRdData(dataRdData), .addrDecr(addrDecr),
    .wrSegStart(wrSegStart), .wrSegEnd(wrSegEnd),
    .rdSegStart(rdSegStart), .rdSegEnd(rdSegEnd),
    .compareReq(compareReq), .addrOut(addrOut)
  );

  task automatic check(input int req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // each operation starts and ends at a falling edge
  task automatic doOp(input logic [2:0] op, input logic [15:0] val,
                      input logic [15:0] exp, input int req);
    case (op)
      OP_CMD: begin cmdValid = 1'b1; cmdData = val; end
      OP_WR:  begin dataWrValid = 1'b1; dataWrData = val; end
      OP_RD:  begin check(req, "read data", dataRdData, exp); dataRdValid = 1'b1; end
      OP_CMP: check(req, "compareReq", {15'd0, compareReq}, exp);
      OP_AR:  check(req, "address", 16'(addrOut), exp);
      default: ;
    endcase
    @(negedge clk);
    cmdValid = 1'b0; dataWrValid = 1'b0; dataRdValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(1, "reset compareReq", {15'd0, compareReq}, 16'h0);
    check(1, "reset address", 16'(addrOut), 16'h0);
    check(1, "reset read data", dataRdData, 16'h0);

    for (int i = 0; i < NV; i++)
      doOp(VEC[i][38:36], VEC[i][35:20], VEC[i][19:4], int'(VEC[i][3:0]));

    // R7 count down wraps below zero
    addrDecr = 1'b1;
    doOp(OP_CMD, 16'h0920, 16'h0, 7);
    doOp(OP_CMD, 16'h0000, 16'h0, 7);
    for (int k = 0; k < 4; k++) doOp(OP_WR, 16'hC000, 16'h0, 7);
    doOp(OP_AR, 16'h0, 16'h000F, 7);   // R7
    addrDecr = 1'b0;

    // R8 windows: write segments 1..3, read segment 0 only
    wrSegStart = 2'd1; wrSegEnd = 2'd3; rdSegStart = 2'd0; rdSegEnd = 2'd0;
    doOp(OP_CMD, 16'h0100, 16'h0, 8);
    doOp(OP_WR, 16'h5555, 16'h0, 8);
    doOp(OP_WR, 16'h6666, 16'h0, 8);
    doOp(OP_WR, 16'h7777, 16'h0, 8);
    doOp(OP_CMP, 16'h0, 16'h0001, 8);  // R8 final segment is 3
    doOp(OP_CMD, 16'h0000, 16'h0, 8);
    doOp(OP_RD, 16'h0, 16'hAB11, 8);
    doOp(OP_RD, 16'h0, 16'hAB11, 8);   // R8 one-segment window
    rdSegStart = 2'd2; rdSegEnd = 2'd2;
    doOp(OP_CMD, 16'h0000, 16'h0, 8);
    doOp(OP_RD, 16'h0, 16'h6666, 8);

    // R3 mask register 2 as destination and source
    doOp(OP_CMD, 16'h0110, 16'h0, 3);
    for (int k = 0; k < 3; k++) doOp(OP_WR, 16'h0F0F, 16'h0, 3);
    doOp(OP_CMP, 16'h0, 16'h0001, 5);  // R5
    doOp(OP_CMD, 16'h0002, 16'h0, 3);
    doOp(OP_RD, 16'h0, 16'h0F0F, 3);   // R3
    doOp(OP_CMD, 16'h0000, 16'h0, 3);
    doOp(OP_RD, 16'h0, 16'h6666, 3);   // R3 comparand untouched

    // R1 mid-run reset restores defaults
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    wrSegStart = 2'd0; wrSegEnd = 2'd3; rdSegStart = 2'd0; rdSegEnd = 2'd3;
    @(negedge clk);
    doOp(OP_AR, 16'h0, 16'h0000, 1);
    doOp(OP_RD, 16'h0, 16'h0000, 1);
    doOp(OP_CMD, 16'h0000, 16'h0, 1);
    for (int k = 0; k < 4; k++) doOp(OP_WR, 16'h9999, 16'h0, 1);
    doOp(OP_CMP, 16'h0, 16'h0001, 1);  // R1 default destination is comparand
    doOp(OP_RD, 16'h0, 16'h9999, 1);   // R1

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule